// File: doc/BRIEF.md
# RTC Update-Busy and Interrupt Flag Controller

This block sits next to the time and calendar counters of a real-time clock whose timebase is a 32.768 kHz tick enable. While those counters are changing it raises a busy flag. Software must not read or write the counters during that window, and the block itself blocks counter writes that arrive during it. It also produces two interrupt sources on one shared active-low interrupt output: a periodic (cyclic) interrupt and an alarm interrupt. Each source has a status flag that can be read.

Four events start the busy window:
- a ±30 s adjust request
- a +1 s correction, which happens when a one-second carry falls in the same cycle as the write-enable bit going from 0 to 1
- a plain one-second carry
- a counter reset

A plain carry holds busy for three 32.768 kHz periods. The other three events hold it for four. The cyclic interrupt runs in pulse mode or level mode. In pulse mode it gives a one-period low pulse and its flag cannot be written. In level mode it holds until software writes 0 to the flag, and the interrupt line is released on the next tick after that write.

Top module: `rtc_flag_ctrl`

## Requirements
- R1: After reset: busy, cyclic flag, alarm flag, collision flag and all request pulses are 0, and int_n is 1.
- R2: A write to the adjust bit (adj_wr) gives a one-clock adj_req pulse. busy then stays 1 for exactly LONG_TICKS (4) tick periods.
- R3: A write of 1 to the reset bit (rst_wr) gives a one-clock cnt_reset pulse. busy then stays 1 for exactly LONG_TICKS (4) tick periods.
- R4: A one-second carry (sec_carry) while write-enable is unchanged keeps busy at 1 for exactly SHORT_TICKS (3) tick periods, and gives no plus1_req.
- R5: A sec_carry in the same cycle as a write that takes write-enable from 0 to 1 (wen_wr=1, wen_val=1) gives a one-clock plus1_req pulse. busy then stays 1 for LONG_TICKS (4) tick periods.
- R6: A counter write (time_wr) while busy is 0 shows as time_wr_en=1 in the next cycle. While busy is 1 it is blocked, with time_wr_en=0, and it sets the sticky wr_collide flag.
- R7: In pulse mode (level_mode=0), a tick-aligned period_stb sets cy_flag and drives int_n low for exactly one tick period (TICK_DIV clocks in the bench). Writes to the cyclic flag have no effect.
- R8: In level mode (level_mode=1), cy_flag stays 1 across ticks until cy_wr with cy_val=0. A cy_wr with cy_val=1 has no effect.
- R9: In level mode, once the cyclic flag is cleared, int_n stays low until the first tick after the clear and goes high on the clock edge of that tick.
- R10: alarm_stb sets al_flag and drives int_n low. al_wr with al_val=0 clears it and releases int_n in the same cycle. al_wr with al_val=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 32.768 kHz enable, one clock wide |
| sec_carry | input | 1 | One-second carry strobe into the seconds digit |
| period_stb | input | 1 | Preset cyclic-interrupt period strobe, tick aligned |
| alarm_stb | input | 1 | Alarm time match strobe |
| level_mode | input | 1 | 0 = pulse mode, 1 = level mode for the cyclic interrupt |
| adj_wr | input | 1 | Write of 1 to the ±30 s adjust bit |
| rst_wr | input | 1 | Write of 1 to the counter reset bit |
| wen_wr | input | 1 | Write strobe for the write-enable bit |
| wen_val | input | 1 | Value written to the write-enable bit |
| cy_wr | input | 1 | Write strobe for the cyclic flag |
| cy_val | input | 1 | Value written to the cyclic flag |
| al_wr | input | 1 | Write strobe for the alarm flag |
| al_val | input | 1 | Value written to the alarm flag |
| time_wr | input | 1 | Write strobe aimed at the time counters |
| busy | output | 1 | Counters are updating |
| cy_flag | output | 1 | Cyclic interrupt flag |
| al_flag | output | 1 | Alarm flag |
| int_n | output | 1 | Shared active-low interrupt |
| cnt_reset | output | 1 | Pulse that resets the counters and the 1 to 8 Hz dividers |
| adj_req | output | 1 | Pulse that requests the ±30 s adjustment |
| plus1_req | output | 1 | Pulse that requests the +1 s correction |
| time_wr_en | output | 1 | Counter write admitted (registered) |
| wr_collide | output | 1 | Sticky: a counter write hit a busy window |

## Verification
The busy window is measured by counting tick periods for each of the four causes separately. Doing so separates the three-period carry length from the four-period length. It also separates a plain carry from a carry that lands on a write-enable rising edge. The cyclic flag is driven in both modes with tick-aligned strobes, mixed with flag writes of 0 and of 1. These patterns show whether the write protection depends on the mode, and they place the level-mode release on the right tick. The alarm flag and the counter-write gate are each tried with both write values and with both busy states.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
  typedef enum logic {IRQ_PULSE = 1'b0, IRQ_LEVEL = 1'b1} irq_mode_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rtc_busy_timer.sv
module rtc_busy_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = (load_val > cnt_q) ? load_val : cnt_q;
    end else if (tick && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= (cnt_d != '0);
    end
  end

  // R2
  busy_needs_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R4
  busy_counts_down_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_flag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic period_stb,
  input  logic alarm_stb,
  input  logic level_mode,
  input  logic cy_wr,
  input  logic cy_val,
  input  logic al_wr,
  input  logic al_val,
  output logic cy_flag,
  output logic al_flag,
  output logic int_n
);
  irq_mode_e mode;
  logic cy_d, hold_q, hold_d, al_d, cy_clr;

  assign mode   = irq_mode_e'(level_mode);
  assign cy_clr = (mode == IRQ_LEVEL) && cy_wr && !cy_val;

  always_comb begin
    cy_d   = cy_flag;
    hold_d = hold_q;
    if (tick) hold_d = 1'b0;
    if (mode == IRQ_PULSE) begin
      if (tick) cy_d = 1'b0;
    end else if (cy_clr) begin
      cy_d = 1'b0;
      if (cy_flag) hold_d = 1'b1;
    end
    if (period_stb) begin
      cy_d   = 1'b1;
      hold_d = 1'b0;
    end
    al_d = al_flag;
    if (al_wr && !al_val) al_d = 1'b0;
    if (alarm_stb) al_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cy_flag <= 1'b0;
      hold_q  <= 1'b0;
      al_flag <= 1'b0;
      int_n   <= 1'b1;
    end else begin
      cy_flag <= cy_d;
      hold_q  <= hold_d;
      al_flag <= al_d;
      int_n   <= !(cy_d || hold_d || al_d);
    end
  end

  // R7
  pulse_ends_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && cy_flag && tick && !period_stb) |=> !cy_flag);

  // R8
  level_flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (level_mode && cy_flag && !cy_wr) |=> cy_flag);

  // R10
  alarm_drives_int_chk: assert property (@(posedge clk) disable iff (rst)
    al_flag |-> !int_n);

  // R10
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (al_flag && !(al_wr && !al_val)) |=> al_flag);
endmodule

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl
  import rtc_flag_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 4,
  parameter int unsigned SHORT_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sec_carry,
  input  logic period_stb,
  input  logic alarm_stb,
  input  logic level_mode,
  input  logic adj_wr,
  input  logic rst_wr,
  input  logic wen_wr,
  input  logic wen_val,
  input  logic cy_wr,
  input  logic cy_val,
  input  logic al_wr,
  input  logic al_val,
  input  logic time_wr,
  output logic busy,
  output logic cy_flag,
  output logic al_flag,
  output logic int_n,
  output logic cnt_reset,
  output logic adj_req,
  output logic plus1_req,
  output logic time_wr_en,
  output logic wr_collide
);
  localparam int unsigned MAXT = umax(LONG_TICKS, SHORT_TICKS);
  localparam int unsigned CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_TICKS);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_TICKS);

  logic wen_q, wen_rise, corr, long_cause, start;
  logic [CW-1:0] load_val;

  assign wen_rise   = wen_wr && wen_val && !wen_q;
  assign corr       = sec_carry && wen_rise;
  assign long_cause = adj_wr || rst_wr || corr;
  assign start      = long_cause || sec_carry;
  assign load_val   = long_cause ? LONG_V : SHORT_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q      <= 1'b0;
      adj_req    <= 1'b0;
      cnt_reset  <= 1'b0;
      plus1_req  <= 1'b0;
      time_wr_en <= 1'b0;
      wr_collide <= 1'b0;
    end else begin
      if (wen_wr) wen_q <= wen_val;
      adj_req    <= adj_wr;
      cnt_reset  <= rst_wr;
      plus1_req  <= corr;
      time_wr_en <= time_wr && !busy;
      wr_collide <= wr_collide || (time_wr && busy);
    end
  end

  rtc_busy_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .start(start),
    .load_val(load_val), .busy(busy)
  );

  rtc_irq_flags u_flags (
    .clk(clk), .rst(rst), .tick(tick), .period_stb(period_stb),
    .alarm_stb(alarm_stb), .level_mode(level_mode),
    .cy_wr(cy_wr), .cy_val(cy_val), .al_wr(al_wr), .al_val(al_val),
    .cy_flag(cy_flag), .al_flag(al_flag), .int_n(int_n)
  );

  // R6
  no_write_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    time_wr_en |-> !$past(busy));

  // R6
  collide_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wr_collide |=> wr_collide);

  // R5
  plus1_busy_chk: assert property (@(posedge clk) disable iff (rst)
    plus1_req |-> busy);
endmodule

// File: tb/rtc_flag_ctrl_bench.sv
module rtc_flag_ctrl_bench;
  localparam int TICK_DIV = 8;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic sec_carry = 0, period_stb = 0, alarm_stb = 0, level_mode = 0;
  logic adj_wr = 0, rst_wr = 0, wen_wr = 0, wen_val = 0;
  logic cy_wr = 0, cy_val = 0, al_wr = 0, al_val = 0, time_wr = 0;
  logic busy, cy_flag, al_flag, int_n, cnt_reset, adj_req, plus1_req;
  logic time_wr_en, wr_collide;
  int tcnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == TICK_DIV - 2);
  end

  rtc_flag_ctrl u_rtc_flag_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .sec_carry(sec_carry),
    .period_stb(period_stb), .alarm_stb(alarm_stb), .level_mode(level_mode),
    .adj_wr(adj_wr), .rst_wr(rst_wr), .wen_wr(wen_wr), .wen_val(wen_val),
    .cy_wr(cy_wr), .cy_val(cy_val), .al_wr(al_wr), .al_val(al_val),
    .time_wr(time_wr), .busy(busy), .cy_flag(cy_flag), .al_flag(al_flag),
    .int_n(int_n), .cnt_reset(cnt_reset), .adj_req(adj_req),
    .plus1_req(plus1_req), .time_wr_en(time_wr_en), .wr_collide(wr_collide)
  );

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_quiet();
    step();
    while (tick) step();
  endtask

  task automatic to_tick();
    step();
    while (!tick) step();
  endtask

  task automatic measure_busy(output int n);
    n = 0;
    for (int i = 0; i < 10 * TICK_DIV; i++) begin
      if (!busy) break;
      if (tick) n++;
      step();
    end
  endtask

  task automatic t_reset();
    chk(!busy && !cy_flag && !al_flag && int_n && !wr_collide, "R1", {busy, cy_flag, al_flag, int_n, wr_collide}, 5'b00010);
    chk(!adj_req && !cnt_reset && !plus1_req && !time_wr_en, "R1", {adj_req, cnt_reset, plus1_req, time_wr_en}, 0);
  endtask

  task automatic t_adjust();
    int n;
    to_quiet();
    adj_wr = 1; step(); adj_wr = 0;
    chk(adj_req == 1, "R2 adj_req pulse", adj_req, 1);
    measure_busy(n);
    chk(n == 4, "R2 busy ticks", n, 4);
    to_quiet();
    chk(adj_req == 0, "R2 adj_req single", adj_req, 0);
  endtask

  task automatic t_counter_reset();
    int n;
    to_quiet();
    rst_wr = 1; step(); rst_wr = 0;
    chk(cnt_reset == 1, "R3 cnt_reset pulse", cnt_reset, 1);
    measure_busy(n);
    chk(n == 4, "R3 busy ticks", n, 4);
  endtask

  task automatic t_carry();
    int n;
    to_quiet();
    sec_carry = 1; step(); sec_carry = 0;
    chk(plus1_req == 0, "R4 no plus1", plus1_req, 0);
    measure_busy(n);
    chk(n == 3, "R4 busy ticks", n, 3);
  endtask

  task automatic t_correction();
    int n;
    to_quiet();
    wen_wr = 1; wen_val = 0; step(); wen_wr = 0;
    to_quiet();
    sec_carry = 1; wen_wr = 1; wen_val = 1; step();
    sec_carry = 0; wen_wr = 0;
    chk(plus1_req == 1, "R5 plus1 pulse", plus1_req, 1);
    measure_busy(n);
    chk(n == 4, "R5 busy ticks", n, 4);
    to_quiet();
    sec_carry = 1; wen_wr = 1; wen_val = 1; step();
    sec_carry = 0; wen_wr = 0;
    chk(plus1_req == 0, "R5 no plus1 when already enabled", plus1_req, 0);
    measure_busy(n);
    chk(n == 3, "R4 carry with write-enable held", n, 3);
  endtask

  task automatic t_write_gate();
    to_quiet();
    time_wr = 1; step(); time_wr = 0;
    chk(time_wr_en == 1 && wr_collide == 0, "R6 idle write", {time_wr_en, wr_collide}, 2'b10);
    to_quiet();
    adj_wr = 1; step(); adj_wr = 0;
    time_wr = 1; step(); time_wr = 0;
    chk(time_wr_en == 0 && wr_collide == 1, "R6 busy write blocked", {time_wr_en, wr_collide}, 2'b01);
    for (int i = 0; i < 6 * TICK_DIV; i++) step();
    chk(wr_collide == 1 && busy == 0, "R6 collide sticky", {wr_collide, busy}, 2'b10);
  endtask

  task automatic t_pulse_mode();
    int n = 0;
    level_mode = 0;
    to_tick();
    period_stb = 1; step(); period_stb = 0;
    for (int i = 0; i < 4 * TICK_DIV; i++) begin
      if (cy_flag && !int_n) n++;
      if (i == 2) begin cy_wr = 1; cy_val = 0; end
      else if (i == 4) begin cy_wr = 1; cy_val = 1; end
      else cy_wr = 0;
      step();
    end
    cy_wr = 0;
    chk(n == TICK_DIV, "R7 pulse width clocks", n, TICK_DIV);
    cy_wr = 1; cy_val = 1; step(); cy_wr = 0; step();
    chk(cy_flag == 0 && int_n == 1, "R7 write 1 ignored", {cy_flag, int_n}, 2'b01);
  endtask

  task automatic t_level_mode();
    bit seen;
    level_mode = 1;
    to_tick();
    period_stb = 1; step(); period_stb = 0;
    for (int i = 0; i < 3 * TICK_DIV; i++) step();
    chk(cy_flag == 1 && int_n == 0, "R8 held across ticks", {cy_flag, int_n}, 2'b10);
    to_quiet();
    cy_wr = 1; cy_val = 1; step(); cy_wr = 0;
    chk(cy_flag == 1, "R8 write 1 ignored", cy_flag, 1);
    to_quiet();
    cy_wr = 1; cy_val = 0; step(); cy_wr = 0;
    chk(cy_flag == 0, "R8 write 0 clears", cy_flag, 0);
    seen = 0;
    for (int i = 0; i < 2 * TICK_DIV && !seen; i++) begin
      if (tick) seen = 1;
      else chk(int_n == 0, "R9 held before tick", int_n, 0);
      step();
    end
    chk(int_n == 1, "R9 released after tick", int_n, 1);
    level_mode = 0;
  endtask

  task automatic t_alarm();
    to_quiet();
    alarm_stb = 1; step(); alarm_stb = 0;
    chk(al_flag == 1 && int_n == 0, "R10 alarm set", {al_flag, int_n}, 2'b10);
    al_wr = 1; al_val = 1; step(); al_wr = 0;
    chk(al_flag == 1 && int_n == 0, "R10 write 1 ignored", {al_flag, int_n}, 2'b10);
    al_wr = 1; al_val = 0; step(); al_wr = 0;
    chk(al_flag == 0 && int_n == 1, "R10 write 0 clears", {al_flag, int_n}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step();
    rst = 0;
    step();
    t_reset();
    t_adjust();
    t_counter_reset();
    t_carry();
    t_correction();
    t_write_gate();
    t_pulse_mode();
    t_level_mode();
    t_alarm();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule